// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves a data word between two ports, A and B, in either direction. Each direction has its own storage register, latch enable, clock and output enable. With the latch enable high, a direction is transparent: its receiving port follows the sending port combinationally. With the latch enable low, the receiving port shows the stored word. That word changes only on a rising edge of that direction's clock, so the direction can hold a value or register it on an edge. The mode is chosen at run time.

Each port is split into an input, an output and a drive enable, so a pad ring or a tri-state wrapper at a higher level forms the real bus. The A-to-B output enable is active high. The B-to-A output enable is active low. A port whose enable is inactive has its drive enable low and its output data forced to zero. Reset clears both stored words and stops either port from being driven.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While rst_ni is low, a_oe_o, b_oe_o, a_o and b_o are all zero, and both stored words are cleared to zero. After release, with the latch enable low and no clock edge, the enabled port outputs zero.
- R2: With le_ab_i high and B enabled, b_o equals a_i in the same cycle, with no clock edge needed.
- R3: With le_ab_i low, b_o equals the value a_i had at the most recent rising edge of clk_ab_i.
- R4: With le_ab_i low and no rising edge on clk_ab_i, b_o stays constant while a_i changes.
- R5: The A-to-B store loads a_i on every rising edge of clk_ab_i whatever the level of le_ab_i. Dropping le_ab_i therefore shows the last clocked word, not the last transparent word.
- R6: B-to-A behaves like A-to-B using b_i, le_ba_i, clk_ba_i and a_o. The two directions are independent: edges and enables of one direction never change the other direction's output.
- R7: b_oe_o equals oe_ab_i (active high) and a_oe_o equals the inverse of oe_ba_ni (active low) outside reset. B is never driven while oe_ab_i is low, and A is never driven while oe_ba_ni is high.
- R8: A port whose drive enable is low outputs all-zero data.
- R9: With both output enables asserted, both ports are driven at once, each with its own direction's value.
- R10: The word width is the parameter WIDTH, 18 by default, and every bit carries data independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_ab_i | input | 1 | A-to-B store clock, rising edge |
| clk_ba_i | input | 1 | B-to-A store clock, rising edge |
| le_ab_i | input | 1 | A-to-B transparent when high |
| le_ba_i | input | 1 | B-to-A transparent when high |
| oe_ab_i | input | 1 | Drive B, active high |
| oe_ba_ni | input | 1 | Drive A, active low |
| a_i | input | WIDTH | Data sensed on port A |
| a_o | output | WIDTH | Data driven onto port A |
| a_oe_o | output | 1 | Drive enable for port A |
| b_i | input | WIDTH | Data sensed on port B |
| b_o | output | WIDTH | Data driven onto port B |
| b_oe_o | output | 1 | Drive enable for port B |

## Verification
The bench builds the block with the default WIDTH of 18. Random words therefore toggle every bit of both directions, including the top bit where an off-by-one width slip would show. Both enable polarities appear in every combination, including the case where both ports are driven at once. Random clock pulses fall in every latch-enable state, so stores that load while transparent and then show up once the latch enable drops (R5) are reached as well as plain hold and capture.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_WIDTH = 18;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned WIDTH = xcvr_pkg::XCVR_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else         q_r <= d_i;
  end

  assign q_o = q_r;

  AST_STORE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> q_o == $past(d_i)); // R5
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int unsigned WIDTH         = xcvr_pkg::XCVR_WIDTH,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic             oe_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             drv_o
);
  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] sel;
  logic             en;

  xcvr_store #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (d_i),
    .q_o    (stored)
  );

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign en = ~oe_i;
    end else begin : g_oe_high
      assign en = oe_i;
    end
  endgenerate

  // transparent bypass when latch enable is high
  assign sel   = le_i ? d_i : stored;
  assign drv_o = en & rst_ni;
  assign q_o   = drv_o ? sel : '0;

  AST_FLOAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_o |-> q_o == '0); // R8
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int unsigned WIDTH = xcvr_pkg::XCVR_WIDTH
) (
  input  logic             rst_ni,
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             le_ab_i,
  input  logic             le_ba_i,
  input  logic             oe_ab_i,
  input  logic             oe_ba_ni,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  xcvr_path #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk_i  (clk_ab_i),
    .rst_ni (rst_ni),
    .le_i   (le_ab_i),
    .oe_i   (oe_ab_i),
    .d_i    (a_i),
    .q_o    (b_o),
    .drv_o  (b_oe_o)
  );

  xcvr_path #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk_i  (clk_ba_i),
    .rst_ni (rst_ni),
    .le_i   (le_ba_i),
    .oe_i   (oe_ba_ni),
    .d_i    (b_i),
    .q_o    (a_o),
    .drv_o  (a_oe_o)
  );

  AST_B_QUIET: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !oe_ab_i |-> !b_oe_o); // R7
  AST_A_QUIET: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    oe_ba_ni |-> !a_oe_o); // R7

  always_comb begin
    if (rst_ni == 1'b0) begin
      AST_RESET_IDLE: assert (!a_oe_o && !b_oe_o); // R1
    end
  end
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int unsigned W = 18;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_ni = 1'b0;
  logic         clk_ab = 1'b0, clk_ba = 1'b0;
  logic         le_ab = 1'b0, le_ba = 1'b0, oe_ab = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int checks = 0, fails = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  bus_xcvr_reg #(.WIDTH(W)) u0 (
    .rst_ni(rst_ni), .clk_ab_i(clk_ab), .clk_ba_i(clk_ba),
    .le_ab_i(le_ab), .le_ba_i(le_ba), .oe_ab_i(oe_ab), .oe_ba_ni(oe_ba_n),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  function automatic logic [W-1:0] exp_b();
    if (!rst_ni || !oe_ab) return '0;
    return le_ab ? a_in : m_ab;
  endfunction

  function automatic logic [W-1:0] exp_a();
    if (!rst_ni || oe_ba_n) return '0;
    return le_ba ? b_in : m_ba;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, b_out, exp_b());
    chk(req, a_out, exp_a());
    chk({req, " R7 oe"}, {17'd0, b_oe}, {17'd0, rst_ni & oe_ab});
    chk({req, " R7 oe"}, {17'd0, a_oe}, {17'd0, rst_ni & ~oe_ba_n});
  endtask

  task automatic pulse_ab();
    #1 clk_ab = 1'b1;
    if (rst_ni) m_ab = a_in;
    #1 clk_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    #1 clk_ba = 1'b1;
    if (rst_ni) m_ba = b_in;
    #1 clk_ba = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset with everything enabled and transparent
    oe_ab = 1'b1; oe_ba_n = 1'b0; le_ab = 1'b1; le_ba = 1'b1;
    a_in = 18'h2AAAA; b_in = 18'h15555;
    pulse_ab(); pulse_ba();
    #1 check_all("R1 reset");
    @(negedge clk) rst_ni = 1'b1;
    le_ab = 1'b0; le_ba = 1'b0;
    #1 chk("R1 cleared b", b_out, '0);
    chk("R1 cleared a", a_out, '0);

    // R2 transparent, full width R10
    le_ab = 1'b1; a_in = 18'h3FFFF;
    #1 chk("R2 R10 transparent", b_out, 18'h3FFFF);
    // R3 clocked capture
    le_ab = 1'b0; a_in = 18'h20001; pulse_ab();
    #1 chk("R3 capture", b_out, 18'h20001);
    // R4 hold while input moves
    a_in = 18'h0F0F0;
    #1 chk("R4 hold", b_out, 18'h20001);
    // R5 load while transparent, then drop le
    le_ab = 1'b1; a_in = 18'h12345; pulse_ab(); a_in = 18'h00777;
    #1 chk("R2 transparent live", b_out, 18'h00777);
    le_ab = 1'b0;
    #1 chk("R5 last clocked", b_out, 18'h12345);
    // R6 independence: AB edge leaves A side alone
    b_in = 18'h3C3C3; pulse_ba(); b_in = 18'h00001; pulse_ab();
    #1 chk("R6 ba stored", a_out, 18'h3C3C3);
    // R8 float zero / R7 polarity
    oe_ab = 1'b0; oe_ba_n = 1'b1;
    #1 check_all("R8 R7 disabled");
    chk("R8 b zero", b_out, '0);
    // R9 both enabled
    oe_ab = 1'b1; oe_ba_n = 1'b0;
    #1 check_all("R9 both driven");

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      le_ab = 1'($urandom); le_ba = 1'($urandom);
      oe_ab = 1'($urandom); oe_ba_n = 1'($urandom);
      a_in = W'($urandom); b_in = W'($urandom);
      if ($urandom % 2) pulse_ab();
      if ($urandom % 2) pulse_ba();
      if ($urandom % 3 == 0) a_in = W'($urandom);
      #1 check_all("R3 R4 R6 R9 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule